// File: doc/BRIEF.md
# Quad-Output Flash Boot Reader

This block pulls a boot image out of a serial NOR flash using one fixed quad-output fast-read sequence. A pulse on the start input latches the requested byte count and three strap inputs. The block then drops one of two active-low chip selects and shifts a one-line command and address out to the flash. After the dummy clocks it gathers four bits per serial clock from the flash and presents whole bytes on a valid/ready stream.

The serial clock comes from the system clock through an integer divider. While the stream sink refuses a byte, the serial clock halts, so the flash never gets ahead of the consumer. When the last byte has been taken and chip select has been released, a one-cycle done pulse marks the end of the read. A zero-length request finishes at once and never touches the flash.

Top module: `qboot_reader`

## Requirements
- R1: Only the chip select picked by `strap_csel_i` (0 selects `cs_n_o[0]`, 1 selects `cs_n_o[1]`) is driven low during a transfer. The other chip select stays high, and both are high while idle and out of reset.
- R2: The first 8 serial clocks carry the opcode 0x6B on `dq_o`, most significant bit first, with `dq_oe_o` high.
- R3: The next 24 serial clocks carry an all-zero address on `dq_o`.
- R4: Exactly 8 dummy clocks follow the address, with `dq_oe_o` low from the first dummy clock onward. The transfer as a whole has exactly 40 + 2×length rising serial clock edges.
- R5: Each output byte comes from two consecutive rising-edge samples of `dq_i`. The first sample gives bits 7:4 and the second gives bits 3:0, and `dq_i[3]` is the most significant bit of each nibble.
- R6: The serial clock is low while idle. While running, one period is `SYS_DIV` system cycles (low for `SYS_DIV/2` of them). `dq_o` changes only together with a falling serial clock edge.
- R7: While `m_valid_o` is high and `m_ready_i` is low, the serial clock and `m_data_o` hold still. No byte is lost, duplicated or reordered.
- R8: Exactly `len_i` bytes are delivered. `done_o` is a one-cycle pulse after the last byte is accepted, with both chip selects already high. Chip select rises at least `SYS_DIV` system cycles after the last data sample.
- R9: A start pulse that arrives while a transfer is running has no effect on the length, the chip select or the strap outputs.
- R10: A start with a length of zero raises `done_o` in the cycle right after the start edge, produces no bytes, and never asserts a chip select.
- R11: `port_sel_o` and `iclk_int_o` show the values of `strap_port_i` and `strap_iclk_i` taken at the accepted start, and hold them until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a read (only acted on while idle) |
| len_i | input | LEN_W | Number of bytes to read |
| strap_csel_i | input | 1 | Selects the chip select that holds the boot flash |
| strap_port_i | input | 1 | Flash port selection strap |
| strap_iclk_i | input | 1 | Reference clock source strap (1 = internal) |
| port_sel_o | output | 1 | Latched port selection |
| iclk_int_o | output | 1 | Latched clock source selection |
| sclk_o | output | 1 | Serial flash clock |
| cs_n_o | output | 2 | Active-low chip selects |
| dq_o | output | 1 | Serial command and address output line |
| dq_oe_o | output | 1 | Output enable for `dq_o` |
| dq_i | input | 4 | Quad data input lines from the flash |
| m_valid_o | output | 1 | Stream byte valid |
| m_data_o | output | 8 | Stream byte |
| m_ready_i | input | 1 | Stream sink ready |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The chip select, the strap outputs and the first serial clock low phase all begin at the system edge that samples start. The first rising serial edge follows `SYS_DIV/2` cycles later. A byte becomes valid at the edge of its second nibble's rising serial edge, and `done_o` comes no sooner than `SYS_DIV` cycles after the last nibble, once that byte has left the output register. With a zero length, `done_o` is due exactly one edge after start. The bench drives all inputs and samples all outputs on the falling system clock edge, so each registered result is seen one half-cycle after the edge that makes it. Its flash model keys on observed serial clock edges rather than fixed delays, so clock stalls under random backpressure cannot shift the expected data.

// File: rtl/qboot_pkg.sv
// Shared constants and state encoding for the quad-output flash boot reader.
// Assumes a 1-1-4 single-data-rate read with a fixed opcode and zero address.
package qboot_pkg;
    localparam logic [7:0] QB_OPCODE     = 8'h6B;
    localparam int         QB_CMD_BITS   = 8;
    localparam int         QB_ADDR_BITS  = 24;
    localparam int         QB_DUMMY_CLKS = 8;
    localparam int         QB_NUM_CS     = 2;

    typedef enum logic [2:0] {
        QB_IDLE,
        QB_SEND,
        QB_DUMMY,
        QB_DATA,
        QB_HOLD,
        QB_DONE
    } qb_state_e;
endpackage

// File: rtl/qboot_sclk_gen.sv
// Serial clock divider. While run_i is high it produces one serial period
// every DIV system cycles: low for DIV/2 cycles, then high. en_i freezes
// the counter and the clock level (used for stream backpressure).
// rise_o / fall_o flag the system cycle whose closing edge moves sclk_o.
// Assumes DIV >= 2.
module qboot_sclk_gen #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic en_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int LOW = DIV / 2;

    logic [CW-1:0] cnt;

    // Edge flags: decoded from the phase counter while running and enabled.
    assign rise_o = run_i && en_i && (cnt == CW'(LOW - 1));
    assign fall_o = run_i && en_i && (cnt == CW'(DIV - 1));

    // Phase counter and registered serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt    <= '0;
            sclk_o <= 1'b0;
        end else if (en_i) begin
            if (fall_o) begin
                cnt    <= '0;
                sclk_o <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                if (rise_o) sclk_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/qboot_nibble_pack.sv
// Joins two quad samples into one byte: the first sample is the high
// nibble, the second the low nibble. byte_vld_o fires combinationally on
// the second sample, together with the finished byte.
module qboot_nibble_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       sample_i,
    input  logic [3:0] nib_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o
);
    logic [3:0] hi_q;
    logic       half_q;

    // A byte completes when the second nibble of a pair is sampled.
    assign byte_vld_o = sample_i && half_q;
    assign byte_o     = {hi_q, nib_i};

    // Holds the high nibble and tracks which half of the byte comes next.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            hi_q   <= '0;
            half_q <= 1'b0;
        end else if (sample_i) begin
            if (!half_q) hi_q <= nib_i;
            half_q <= !half_q;
        end
    end
endmodule

// File: rtl/qboot_reader.sv
// Quad-output flash boot reader top. Once started it sends opcode 0x6B and
// a zero 24-bit address on one line, waits 8 dummy clocks, then reads
// len_i bytes over four lines into a one-entry valid/ready output register.
// The serial clock halts while that register is full and not being taken.
// Assumes the flash drives data after falling serial edges (SPI mode 0).
module qboot_reader #(
    parameter int SYS_DIV = 3,
    parameter int LEN_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             strap_csel_i,
    input  logic             strap_port_i,
    input  logic             strap_iclk_i,
    output logic             port_sel_o,
    output logic             iclk_int_o,
    output logic             sclk_o,
    output logic [1:0]       cs_n_o,
    output logic             dq_o,
    output logic             dq_oe_o,
    input  logic [3:0]       dq_i,
    output logic             m_valid_o,
    output logic [7:0]       m_data_o,
    input  logic             m_ready_i,
    output logic             done_o
);
    import qboot_pkg::*;

    localparam int SH_W = QB_CMD_BITS + QB_ADDR_BITS;
    localparam int BC_W = $clog2(SH_W);
    localparam int DC_W = $clog2(QB_DUMMY_CLKS);
    localparam int HC_W = (SYS_DIV > 2) ? $clog2(SYS_DIV) : 1;

    qb_state_e              state;
    logic [SH_W-1:0]        shreg;
    logic [BC_W-1:0]        bit_cnt;
    logic [DC_W-1:0]        dmy_cnt;
    logic [HC_W-1:0]        hold_cnt;
    logic [LEN_W-1:0]       bytes_left;
    logic [QB_NUM_CS-1:0]   cs_sel;
    logic                   run, sclk_en, rise, fall;
    logic                   byte_vld;
    logic [7:0]             byte_val;

    // Divider runs during the serial phases; stalls only in the data phase.
    assign run     = (state == QB_SEND) || (state == QB_DUMMY) || (state == QB_DATA);
    assign sclk_en = (state != QB_DATA) || !m_valid_o || m_ready_i;

    qboot_sclk_gen #(.DIV(SYS_DIV)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .en_i   (sclk_en),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    qboot_nibble_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (state == QB_IDLE),
        .sample_i   (rise && (state == QB_DATA)),
        .nib_i      (dq_i),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_val)
    );

    // Serial output drives only during the command/address phase.
    assign dq_o    = shreg[SH_W-1];
    assign dq_oe_o = (state == QB_SEND);
    assign done_o  = (state == QB_DONE);

    // One-hot selection pattern for each chip select line.
    for (genvar g = 0; g < QB_NUM_CS; g++) begin : g_cs
        assign cs_sel[g] = (g == int'(strap_csel_i));
    end

    // Sequencer: start latch, command shift, dummy count, data count, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= QB_IDLE;
            shreg      <= '0;
            bit_cnt    <= '0;
            dmy_cnt    <= '0;
            hold_cnt   <= '0;
            bytes_left <= '0;
            cs_n_o     <= '1;
            port_sel_o <= 1'b0;
            iclk_int_o <= 1'b0;
        end else begin
            unique case (state)
                QB_IDLE: begin
                    if (start_i) begin
                        port_sel_o <= strap_port_i;
                        iclk_int_o <= strap_iclk_i;
                        bytes_left <= len_i;
                        if (len_i == '0) begin
                            state <= QB_DONE;
                        end else begin
                            state   <= QB_SEND;
                            shreg   <= {QB_OPCODE, {QB_ADDR_BITS{1'b0}}};
                            bit_cnt <= '0;
                            cs_n_o  <= ~cs_sel;
                        end
                    end
                end
                QB_SEND: begin
                    if (fall) begin
                        shreg <= shreg << 1;
                        if (bit_cnt == BC_W'(SH_W - 1)) begin
                            state   <= QB_DUMMY;
                            dmy_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                QB_DUMMY: begin
                    if (fall) begin
                        if (dmy_cnt == DC_W'(QB_DUMMY_CLKS - 1)) state <= QB_DATA;
                        else dmy_cnt <= dmy_cnt + 1'b1;
                    end
                end
                QB_DATA: begin
                    if (byte_vld) bytes_left <= bytes_left - 1'b1;
                    if (fall && bytes_left == '0) begin
                        state    <= QB_HOLD;
                        hold_cnt <= '0;
                    end
                end
                QB_HOLD: begin
                    if (hold_cnt != HC_W'(SYS_DIV - 1)) begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end else if (!m_valid_o) begin
                        state  <= QB_DONE;
                        cs_n_o <= '1;
                    end
                end
                QB_DONE: state <= QB_IDLE;
                default: state <= QB_IDLE;
            endcase
        end
    end

    // One-entry output register: load a finished byte, drop it when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid_o <= 1'b0;
            m_data_o  <= '0;
        end else if (byte_vld) begin
            m_valid_o <= 1'b1;
            m_data_o  <= byte_val;
        end else if (m_ready_i) begin
            m_valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/qboot_reader_chk.sv
// Port-level assertion checker for qboot_reader, attached by bind below.
module qboot_reader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk_o,
    input logic [1:0] cs_n_o,
    input logic       dq_oe_o,
    input logic       m_valid_o,
    input logic [7:0] m_data_o,
    input logic       m_ready_i,
    input logic       done_o,
    input logic       port_sel_o,
    input logic       iclk_int_o
);
    p_cs_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_o) <= 1);

    p_oe_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> !(&cs_n_o));

    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n_o) |-> !sclk_o);

    p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));

    p_stall_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && !m_ready_i) |=> $stable(sclk_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (&cs_n_o));

    p_straps_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n_o) |=> ($stable(port_sel_o) && $stable(iclk_int_o)));
endmodule

bind qboot_reader qboot_reader_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_o     (sclk_o),
    .cs_n_o     (cs_n_o),
    .dq_oe_o    (dq_oe_o),
    .m_valid_o  (m_valid_o),
    .m_data_o   (m_data_o),
    .m_ready_i  (m_ready_i),
    .done_o     (done_o),
    .port_sel_o (port_sel_o),
    .iclk_int_o (iclk_int_o)
);

// File: tb/qboot_reader_tb_top.sv
// Self-checking bench: a behavioural flash model watching sclk/cs at the
// falling system edge, a random-ready stream sink, and directed plus random
// transfers checked against bench-computed expectations.
module qboot_reader_tb_top;
    localparam int DIV = 3;
    localparam int LW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic          strap_csel_i = 1'b0, strap_port_i = 1'b0, strap_iclk_i = 1'b0;
    logic          port_sel_o, iclk_int_o, sclk_o, dq_o, dq_oe_o;
    logic [1:0]    cs_n_o;
    logic [3:0]    dq_i = 4'h0;
    logic          m_valid_o, m_ready_i = 1'b0, done_o;
    logic [7:0]    m_data_o;

    always #5 clk = ~clk;

    qboot_reader #(.SYS_DIV(DIV), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .strap_csel_i(strap_csel_i), .strap_port_i(strap_port_i),
        .strap_iclk_i(strap_iclk_i), .port_sel_o(port_sel_o),
        .iclk_int_o(iclk_int_o), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i), .m_valid_o(m_valid_o),
        .m_data_o(m_data_o), .m_ready_i(m_ready_i), .done_o(done_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0, fails = 0;
    int rc, got, bad_byte, bad_period, bad_oe, bad_other, bad_dqchg;
    int last_nib_cyc, last_rise_cyc, cs_rise_cyc, ready_pct = 100;
    bit cs_low_seen, cur_csel;
    logic [31:0] cmd_sh;
    logic [7:0]  tseed = 8'h00;
    logic prev_sclk = 1'b0, prev_dq = 1'b0, prev_csl = 1'b0, prev_oe = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i);
        return (8'(i * 29) + tseed) ^ 8'(i >> 2);
    endfunction

    // Flash model and stream sink, all evaluated at the falling system edge.
    always @(negedge clk) begin : mon
        logic csl;
        int   nib;
        logic [7:0] b;
        csl = cur_csel ? !cs_n_o[1] : !cs_n_o[0];
        if (rst_n) begin
            if (cur_csel ? !cs_n_o[0] : !cs_n_o[1]) bad_other++;
            if (csl) cs_low_seen = 1'b1;
            if (prev_csl && !csl) cs_rise_cyc = cyc;
            if (csl && !prev_sclk && sclk_o) begin
                if (rc < 32) cmd_sh = {cmd_sh[30:0], dq_o};
                else if (dq_oe_o) bad_oe++;
                if (rc >= 1 && rc < 32 && (cyc - last_rise_cyc) != DIV) bad_period++;
                if (rc >= 40) last_nib_cyc = cyc;
                last_rise_cyc = cyc;
                rc++;
            end
            if (csl && prev_sclk && !sclk_o && rc >= 40) begin
                nib  = rc - 40;
                b    = exp_byte(nib / 2);
                dq_i = (nib % 2 == 0) ? b[7:4] : b[3:0];
            end
            if (csl && prev_csl && dq_oe_o && prev_oe && dq_o != prev_dq && !(prev_sclk && !sclk_o))
                bad_dqchg++;
            m_ready_i = (($urandom % 100) < ready_pct);
            if (m_valid_o && m_ready_i) begin
                if (m_data_o != exp_byte(got)) bad_byte++;
                got++;
            end
        end
        prev_sclk = sclk_o;
        prev_dq   = dq_o;
        prev_csl  = csl;
        prev_oe   = dq_oe_o;
    end

    // Watchdog: a hung run is a failed check and still reaches the summary.
    always @(negedge clk) begin
        if (cyc > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // One transfer; poke_at >= 0 injects a start pulse mid-transfer (R9).
    task automatic xfer(input int len, input bit csel, input bit port, input bit iclk,
                        input int pct, input int poke_at);
        int n;
        @(negedge clk); #1;
        rc = 0; got = 0; bad_byte = 0; bad_period = 0; bad_oe = 0; bad_other = 0;
        bad_dqchg = 0; cmd_sh = '0; cs_low_seen = 1'b0; cur_csel = csel;
        last_nib_cyc = 0; last_rise_cyc = 0; cs_rise_cyc = 0;
        tseed = 8'($urandom); ready_pct = pct;
        start_i = 1'b1; len_i = LW'(len);
        strap_csel_i = csel; strap_port_i = port; strap_iclk_i = iclk;
        @(negedge clk); #1;
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 20000) begin
            if (n == poke_at) begin
                start_i = 1'b1; len_i = LW'(3);
                strap_csel_i = !csel; strap_port_i = !port; strap_iclk_i = !iclk;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk); #1;
            n++;
        end
        start_i = 1'b0;
        check(done_o, "R8 done seen", int'(done_o), 1);
        if (len == 0) check(n == 0, "R10 zero length done next cycle", n, 0);
        check(cs_n_o == 2'b11, "R8 cs high at done", int'(cs_n_o), 3);
        check(port_sel_o == port && iclk_int_o == iclk, "R11 strap outputs",
              {port_sel_o, iclk_int_o}, {port, iclk});
        check(bad_other == 0, "R1 unselected cs stays high", bad_other, 0);
        check(cs_low_seen == (len != 0), "R1/R10 selected cs use", int'(cs_low_seen), int'(len != 0));
        check(got == len, "R8 byte count", got, len);
        check(bad_byte == 0, "R5/R7 byte values and order", bad_byte, 0);
        if (len != 0) begin
            check(cmd_sh[31:24] == 8'h6B, "R2 opcode", int'(cmd_sh[31:24]), 8'h6B);
            check(cmd_sh[23:0] == 24'h0, "R3 address zero", int'(cmd_sh[23:0]), 0);
            check(rc == 40 + 2 * len, "R4 rising edge total", rc, 40 + 2 * len);
            check(bad_oe == 0, "R4 output disabled after address", bad_oe, 0);
            check(bad_period == 0, "R6 serial period", bad_period, 0);
            check(bad_dqchg == 0, "R6 dq changes on falling edge", bad_dqchg, 0);
            check(cs_rise_cyc - last_nib_cyc >= DIV, "R8 cs release gap",
                  cs_rise_cyc - last_nib_cyc, DIV);
        end
        if (poke_at >= 0) check(got == len, "R9 mid-transfer start ignored", got, len);
        @(negedge clk); #1;
        check(!done_o, "R8 done one cycle", int'(done_o), 0);
    endtask

    initial begin
        int idle_bad;
        void'($urandom(32'h5EED1));
        repeat (5) @(negedge clk);
        check(cs_n_o == 2'b11, "R1 reset cs", int'(cs_n_o), 3);
        check(!sclk_o && !dq_oe_o, "R6 reset sclk idle", {sclk_o, dq_oe_o}, 0);
        check(!done_o && !m_valid_o, "R8 reset done/valid", {done_o, m_valid_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        xfer(1, 1'b0, 1'b0, 1'b0, 100, -1);
        xfer(2, 1'b1, 1'b1, 1'b1, 100, -1);
        xfer(0, 1'b1, 1'b0, 1'b1, 100, -1);
        xfer(9, 1'b0, 1'b1, 1'b0, 25, -1);
        xfer(6, 1'b0, 1'b1, 1'b0, 60, 25);
        idle_bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (cs_n_o != 2'b11 || done_o || m_valid_o) idle_bad++;
        end
        check(idle_bad == 0, "R9 no transfer after ignored start", idle_bad, 0);

        for (int i = 0; i < 14; i++) begin
            xfer(int'($urandom % 24), 1'($urandom), 1'($urandom), 1'($urandom),
                 20 + int'($urandom % 81), -1);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule